// File: doc/BRIEF.md
# Restartable Pulse Voice Oscillator

This block is a single tone voice. A 24-bit phase accumulator advances by a 16-bit frequency word on every clock where the clock enable is high. The top twelve accumulator bits make up the phase. That phase is compared with a 12-bit pulse-width word. The one-bit output is high while the phase is below the width and low once the phase reaches it.

A control bit, called hold, clears the accumulator and keeps it at zero. While hold is set, the output is forced high. When software releases hold, the phase climbs from zero. The output then drops by itself once the phase passes the programmed width. Software can therefore start one pulse of a chosen length at any moment.

The accumulator is sequenced by a two-state machine:
- **PH_RUN**: the accumulator accumulates.
- **PH_HOLD**: the accumulator is parked at zero.
- **ENTER_HOLD**: the transition from PH_RUN to PH_HOLD, taken when the hold bit is seen set.
- **RELEASE**: the transition from PH_HOLD to PH_RUN, taken when the hold bit is seen clear.

Top module: `pulse_voice`

## Requirements
- R1: A synchronous reset clears the frequency word, the width word, the hold bit and the accumulator, so `pulse_out` is 0 after reset. Writes made while reset is high are ignored.
- R2: A write with `wr_en` high takes effect at the next clock edge. The address map is:
  - 0 sets frequency bits [7:0];
  - 1 sets frequency bits [15:8];
  - 2 sets width bits [7:0];
  - 3 sets width bits [11:8] from data bits [3:0];
  - 4 sets hold from data bit 0.
  Writes to addresses 5 to 7 change nothing.
- R3: With hold clear and `clk_en` high, each clock edge adds the frequency word to the accumulator, modulo 2^24.
- R4: With hold clear and `clk_en` low, the accumulator keeps its value.
- R5: While hold is set, the accumulator is cleared at the next edge and stays at zero whatever `clk_en` is, and `pulse_out` is 1.
- R6: While hold is clear, `pulse_out` is 1 exactly when accumulator bits [23:12] are below the 12-bit width word.
- R7: With frequency 0x4000 and a width N below 256, `pulse_out` stays high for exactly ceil(N/4) enabled edges after the write that clears hold, counting the output seen right after that write, and then goes low.
- R8: Bits [7:4] of a write to address 3 are ignored, so the width word never exceeds 12 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Accumulator advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pulse_out | output | 1 | Pulse waveform |

## Verification
The hardest case to reach is the one-shot pulse: releasing hold under a known frequency and width and counting the exact number of high cycles, including widths that are not multiples of four and a width of zero. The stimulus loads the width and frequency while hold is set, releases hold with a single write, and counts high samples from that edge onward. A reference model runs in parallel and predicts the output of every cycle, across wrap-around, stalled enables and writes to unused addresses.

// File: rtl/pv_pkg.sv
package pv_pkg;
    localparam int ACC_W  = 24;
    localparam int FREQ_W = 16;
    localparam int PW_W   = 12;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_FREQ_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_FREQ_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_PW_LO   = 3'd2;
    localparam logic [ADDR_W-1:0] A_PW_HI   = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd4;

    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_HOLD = 1'b1
    } phase_state_t;
endpackage

// File: rtl/pv_regfile.sv
module pv_regfile
    import pv_pkg::*;
#(
    parameter int FW = FREQ_W,
    parameter int PW = PW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [FW-1:0]     freq_o,
    output logic [PW-1:0]     width_o,
    output logic              hold_o
);
    localparam int PW_HI_W = PW - 8;

    logic [FW-1:0] freq_q;
    logic [PW-1:0] width_q;
    logic          hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_q  <= '0;
            width_q <= '0;
            hold_q  <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_FREQ_LO: freq_q[7:0]     <= wr_data;
                A_FREQ_HI: freq_q[FW-1:8]  <= wr_data[FW-9:0];
                A_PW_LO:   width_q[7:0]    <= wr_data;
                A_PW_HI:   width_q[PW-1:8] <= wr_data[PW_HI_W-1:0];
                A_CTRL:    hold_q          <= wr_data[0];
                default:   ;
            endcase
        end
    end

    assign freq_o  = freq_q;
    assign width_o = width_q;
    assign hold_o  = hold_q;

    // R2: a write to the frequency low byte lands at the next edge
    a_r2_freq_lo_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_FREQ_LO) |=> (freq_o[7:0] == $past(wr_data)));

    // R8: the width word is limited to 12 bits
    a_r8_width_hi_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_PW_HI) |=> (width_o[PW-1:8] == $past(wr_data[PW_HI_W-1:0])));
endmodule

// File: rtl/pv_phase_acc.sv
module pv_phase_acc
    import pv_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int FW = FREQ_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_en,
    input  logic          hold,
    input  logic [FW-1:0] freq,
    output logic [AW-1:0] acc_o
);
    localparam int PAD_W = AW - FW;

    phase_state_t  state_q, state_d;
    logic [AW-1:0] acc_q, acc_d;
    logic [AW-1:0] step_w;

    assign step_w = {{PAD_W{1'b0}}, freq};

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_RUN;
        else     state_q <= state_d;
    end

    // Transitions: ENTER_HOLD and RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_RUN:  if (hold)  state_d = PH_HOLD;
            PH_HOLD: if (!hold) state_d = PH_RUN;
            default: state_d = PH_RUN;
        endcase
    end

    // Accumulator next value per state
    always_comb begin
        acc_d = acc_q;
        unique case (state_q)
            PH_RUN: begin
                if (hold)        acc_d = '0;
                else if (clk_en) acc_d = acc_q + step_w;
            end
            PH_HOLD: begin
                if (hold)        acc_d = '0;
                else if (clk_en) acc_d = step_w;
                else             acc_d = '0;
            end
            default: acc_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    assign acc_o = acc_q;

    // R1: accumulator is zero on the cycle after reset
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc_o == '0));

    // R3: advance by the frequency word
    a_r3_advance: assert property (@(posedge clk) disable iff (rst)
        (!hold && clk_en) |=> (acc_o == AW'($past(acc_o) + {{PAD_W{1'b0}}, $past(freq)})));

    // R4: stall when the enable is low
    a_r4_stall: assert property (@(posedge clk) disable iff (rst)
        (!hold && !clk_en) |=> $stable(acc_o));

    // R5: hold parks the accumulator at zero
    a_r5_hold_zero: assert property (@(posedge clk) disable iff (rst)
        hold |=> (acc_o == '0));
endmodule

// File: rtl/pv_pulse_cmp.sv
module pv_pulse_cmp
    import pv_pkg::*;
#(
    parameter int PW = PW_W
) (
    input  logic [PW-1:0] phase,
    input  logic [PW-1:0] width,
    input  logic          hold,
    output logic          pulse
);
    always_comb begin
        pulse = hold | (phase < width);
    end
endmodule

// File: rtl/pulse_voice.sv
module pulse_voice
    import pv_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int FW = FREQ_W,
    parameter int PW = PW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              pulse_out
);
    localparam int PH_LSB = AW - PW;

    logic [FW-1:0] freq_w;
    logic [PW-1:0] width_w;
    logic          hold_w;
    logic [AW-1:0] acc_w;

    pv_regfile #(.FW(FW), .PW(PW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .freq_o  (freq_w),
        .width_o (width_w),
        .hold_o  (hold_w)
    );

    pv_phase_acc #(.AW(AW), .FW(FW)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clk_en (clk_en),
        .hold   (hold_w),
        .freq   (freq_w),
        .acc_o  (acc_w)
    );

    pv_pulse_cmp #(.PW(PW)) u_cmp (
        .phase (acc_w[AW-1:PH_LSB]),
        .width (width_w),
        .hold  (hold_w),
        .pulse (pulse_out)
    );

    // R5: output forced high while hold is set
    a_r5_force_high: assert property (@(posedge clk) disable iff (rst)
        hold_w |-> pulse_out);

    // R6: a zero width gives a low output when not held
    a_r6_zero_width_low: assert property (@(posedge clk) disable iff (rst)
        (!hold_w && width_w == '0) |-> !pulse_out);
endmodule

// File: tb/pulse_voice_tb_top.sv
module pulse_voice_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pulse_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    pulse_voice dut_i (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pulse_out (pulse_out)
    );

    // Reference model state
    logic [15:0] m_freq  = '0;
    logic [11:0] m_width = '0;
    logic        m_hold  = 1'b0;
    logic [23:0] m_acc   = '0;

    bit    q_exp[$];
    string q_tag[$];

    task automatic step(input bit r, input bit we, input logic [2:0] a,
                        input logic [7:0] d, input bit en, input string tag);
        @(negedge clk);
        rst = r; wr_en = we; wr_addr = a; wr_data = d; clk_en = en;
        if (r) begin
            m_freq = '0; m_width = '0; m_hold = 1'b0; m_acc = '0;
        end else begin
            if (m_hold)  m_acc = '0;
            else if (en) m_acc = m_acc + {8'd0, m_freq};
            if (we) begin
                case (a)
                    3'd0: m_freq[7:0]    = d;
                    3'd1: m_freq[15:8]   = d;
                    3'd2: m_width[7:0]   = d;
                    3'd3: m_width[11:8]  = d[3:0];
                    3'd4: m_hold         = d[0];
                    default: ;
                endcase
            end
        end
        q_exp.push_back(m_hold | (m_acc[23:12] < m_width));
        q_tag.push_back(tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
        step(1'b0, 1'b1, a, d, 1'b1, tag);
    endtask

    task automatic idle(input int n, input bit en, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 8'd0, en, tag);
    endtask

    // Monitor: compares every result against the scoreboard queue
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                bit    e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                n_checks++;
                if (pulse_out !== e) begin
                    n_fail++;
                    $display("FAIL %s: pulse_out actual %0b expected %0b at %0t", t, pulse_out, e, $time);
                end
            end
        end
    end

    // R7: one-shot pulse length in enabled cycles
    task automatic one_shot(input int n);
        int hi_cnt;
        int expv;
        hi_cnt = 0;
        expv = (n + 3) / 4;
        wr(3'd4, 8'h01, "R7");
        wr(3'd0, 8'h00, "R7");
        wr(3'd1, 8'h40, "R7");
        wr(3'd2, n[7:0], "R7");
        wr(3'd3, 8'h00, "R7");
        wr(3'd4, 8'h00, "R7");
        @(posedge clk); #1;
        if (pulse_out) hi_cnt++;
        for (int i = 0; i < 80; i++) begin
            step(1'b0, 1'b0, 3'd0, 8'd0, 1'b1, "R7");
            @(posedge clk); #1;
            if (pulse_out) hi_cnt++;
        end
        n_checks++;
        if (hi_cnt != expv) begin
            n_fail++;
            $display("FAIL R7: width %0d high cycles actual %0d expected %0d", n, hi_cnt, expv);
        end
    endtask

    initial begin
        // R1: reset state, and writes during reset are ignored
        step(1'b1, 1'b0, 3'd0, 8'd0, 1'b0, "R1");
        step(1'b1, 1'b1, 3'd2, 8'hFF, 1'b1, "R1");
        step(1'b1, 1'b1, 3'd4, 8'h01, 1'b1, "R1");
        idle(4, 1'b1, "R1");

        // R2: register writes and unused addresses
        wr(3'd2, 8'h00, "R2");
        wr(3'd3, 8'h08, "R2");
        wr(3'd0, 8'h00, "R2");
        wr(3'd1, 8'h10, "R2");
        step(1'b0, 1'b1, 3'd7, 8'hFF, 1'b0, "R2");
        step(1'b0, 1'b1, 3'd5, 8'h01, 1'b0, "R2");
        step(1'b0, 1'b1, 3'd6, 8'hAA, 1'b0, "R2");

        // R3: accumulation including wrap-around
        idle(300, 1'b1, "R3");
        wr(3'd0, 8'hFF, "R3");
        wr(3'd1, 8'hFF, "R3");
        idle(600, 1'b1, "R3");

        // R4: stalls interleaved with running
        for (int k = 0; k < 40; k++) begin
            idle(3, 1'b0, "R4");
            idle(2, 1'b1, "R4");
        end

        // R5: hold clears and parks regardless of enable
        wr(3'd4, 8'h01, "R5");
        idle(10, 1'b1, "R5");
        idle(10, 1'b0, "R5");
        wr(3'd4, 8'h00, "R5");
        idle(20, 1'b1, "R5");

        // R6: comparison under several widths and frequencies
        wr(3'd0, 8'h34, "R6");
        wr(3'd1, 8'h12, "R6");
        wr(3'd2, 8'h01, "R6");
        wr(3'd3, 8'h00, "R6");
        idle(300, 1'b1, "R6");
        wr(3'd2, 8'hFF, "R6");
        wr(3'd3, 8'h0F, "R6");
        idle(300, 1'b1, "R6");
        wr(3'd2, 8'h00, "R6");
        wr(3'd3, 8'h00, "R6");
        idle(100, 1'b1, "R6");

        // R8: upper bits of the high nibble write are dropped
        wr(3'd2, 8'h00, "R8");
        wr(3'd3, 8'hF4, "R8");
        wr(3'd1, 8'h20, "R8");
        idle(400, 1'b1, "R8");

        // R7: one-shot lengths
        one_shot(0);
        one_shot(1);
        one_shot(4);
        one_shot(5);
        one_shot(200);
        one_shot(255);

        idle(3, 1'b1, "R6");
        @(posedge clk); #2;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule